// File: doc/BRIEF.md
# Wakeup Threshold and Event Status Registers

This block holds two byte-wide registers of a system error and control unit. Each register sits at a fixed byte offset on a simple synchronous read/write bus. The first is the wakeup control register. It holds an enable bit and a priority threshold. While the enable bit is set, the block raises a registered wakeup request whenever a pending, unmasked interrupt request has a priority strictly above the threshold. Power-management logic uses that request to bring the system out of low-power mode.

The second is the event status register. It gathers four sticky flags, which come from one-cycle event pulses raised by two fabric or memory banks. Each bank supplies an access-class event and a second-class event. A flag stays set until service software writes one to its bit. The OR of all flags drives a single interrupt output. Bits are numbered MSB-first: register bit 0 is data bit 7.

The block carries no state machine. It is built from two register slices, one for wakeup control and one for event status, with a decode and a registered read mux at the top. The decoder sorts each bus access into one of three selections: none, wakeup, or status.

Top module: `wkstat_regs`

## Requirements
- R1: After reset, the enable bit, the threshold, all four flags, `wake_req`, `irq_out` and `bus_rdata` are all zero.
- R2: The wakeup control register is at offset 0x13. The enable bit is at data bit 7 and the threshold at data bits 3:0. Data bits 6:4 always read as zero.
- R3: A write of the all-ones threshold value (15) stores 14. Any other threshold value is stored unchanged.
- R4: `wake_req` is registered. It is 1 in the cycle after a cycle in which the enable bit was 1, `irq_req_valid` was 1 and `irq_req_prio` was greater than the threshold. A priority equal to the threshold does not raise it.
- R5: `wake_req` stays 0 while the enable bit is 0 or while `irq_req_valid` is 0, whatever the priority.
- R6: The status register is at offset 0x1F. A pulse on `evt_pulse[k]` sets flag k, which reads at data bit 7-k. Index 0 is the bank 0 access event, 1 the bank 0 second event, 2 the bank 1 access event and 3 the bank 1 second event. Data bits 3:0 read as zero.
- R7: Flags are sticky. Writing 1 to a flag's data bit clears that flag. Writing 0 leaves it unchanged.
- R8: If an event pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_out` is the OR of the four flags. It rises in the cycle after a setting pulse and falls only once every flag is clear.
- R10: A read of any other offset returns zero. A write to any other offset changes no register.
- R11: `bus_rdata` is updated on the clock edge that ends a read cycle and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_pulse | input | 4 | One-cycle event pulses, index k sets flag k |
| irq_req_valid | input | 1 | An unmasked interrupt request is pending |
| irq_req_prio | input | 4 | Priority of the pending request |
| wake_req | output | 1 | Registered wakeup request |
| irq_out | output | 1 | OR of the status flags |

## Verification
The hardest case to reach from the ports is an event pulse and a write-one clear landing on the same flag in the same clock cycle. The bench lines the two up by driving `evt_pulse` and the status write in the same falling-edge slot. In that same write it also clears a second, already set flag, so one access shows both outcomes. The strict-greater comparison is exercised at the equality point. Threshold saturation is checked by writing the all-ones value and reading it back.

// File: rtl/wkstat_pkg.sv
package wkstat_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_WAKE = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/wkstat_wake.sv
module wkstat_wake #(
    parameter int PRIO_W  = 4,
    parameter bit SAT_TOP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_enable,
    input  logic [PRIO_W-1:0] wr_thr,
    input  logic              req_valid,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              en_q,
    output logic [PRIO_W-1:0] thr_q,
    output logic              wake_req
);

    localparam logic [PRIO_W-1:0] PRIO_TOP  = '1;
    localparam logic [PRIO_W-1:0] PRIO_LIM  = PRIO_TOP - 1'b1;

    logic [PRIO_W-1:0] thr_d;

    generate
        if (SAT_TOP) begin : g_sat
            assign thr_d = (wr_thr == PRIO_TOP) ? PRIO_LIM : wr_thr;
        end else begin : g_nosat
            assign thr_d = wr_thr;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            thr_q <= '0;
        end else if (wr_en) begin
            en_q  <= wr_enable;
            thr_q <= thr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_req <= 1'b0;
        end else begin
            wake_req <= en_q && req_valid && (req_prio > thr_q);
        end
    end

endmodule

// File: rtl/wkstat_flags.sv
module wkstat_flags #(
    parameter int NUM_FLAGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_en,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    input  logic [NUM_FLAGS-1:0] evt,
    output logic [NUM_FLAGS-1:0] flags_q,
    output logic                 irq
);

    logic [NUM_FLAGS-1:0] keep;

    always_comb begin
        keep = flags_q;
        if (clr_en) begin
            keep = flags_q & ~clr_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= keep | evt;
        end
    end

    assign irq = |flags_q;

endmodule

// File: rtl/wkstat_regs.sv
module wkstat_regs
    import wkstat_pkg::*;
#(
    parameter int          PRIO_W    = 4,
    parameter int          NUM_FLAGS = 4,
    parameter bit          SAT_TOP   = 1'b1,
    parameter logic [7:0]  WAKE_OFS  = 8'h13,
    parameter logic [7:0]  STAT_OFS  = 8'h1F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [NUM_FLAGS-1:0] evt_pulse,
    input  logic                 irq_req_valid,
    input  logic [PRIO_W-1:0]    irq_req_prio,
    output logic                 wake_req,
    output logic                 irq_out
);

    localparam int GAP_W = BYTE_W - 1 - PRIO_W;

    reg_sel_e               sel;
    logic                   en_q;
    logic [PRIO_W-1:0]      thr_q;
    logic [NUM_FLAGS-1:0]   flags_q;
    logic [NUM_FLAGS-1:0]   clr_mask;
    logic [BYTE_W-1:0]      stat_view;
    logic [BYTE_W-1:0]      rd_mux;
    logic                   rd_stb;

    always_comb begin
        sel = SEL_NONE;
        if (bus_sel) begin
            if (bus_addr == WAKE_OFS) begin
                sel = SEL_WAKE;
            end else if (bus_addr == STAT_OFS) begin
                sel = SEL_STAT;
            end
        end
    end

    assign rd_stb = bus_sel && !bus_wr;

    wkstat_wake #(
        .PRIO_W  (PRIO_W),
        .SAT_TOP (SAT_TOP)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && (sel == SEL_WAKE)),
        .wr_enable (bus_wdata[BYTE_W-1]),
        .wr_thr    (bus_wdata[PRIO_W-1:0]),
        .req_valid (irq_req_valid),
        .req_prio  (irq_req_prio),
        .en_q      (en_q),
        .thr_q     (thr_q),
        .wake_req  (wake_req)
    );

    generate
        for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_map
            assign clr_mask[k]             = bus_wdata[BYTE_W-1-k];
            assign stat_view[BYTE_W-1-k]   = flags_q[k];
        end
        if (NUM_FLAGS < BYTE_W) begin : g_pad
            assign stat_view[BYTE_W-1-NUM_FLAGS:0] = '0;
        end
    endgenerate

    wkstat_flags #(
        .NUM_FLAGS (NUM_FLAGS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (bus_wr && (sel == SEL_STAT)),
        .clr_mask (clr_mask),
        .evt      (evt_pulse),
        .flags_q  (flags_q),
        .irq      (irq_out)
    );

    always_comb begin
        unique case (sel)
            SEL_WAKE: rd_mux = {en_q, {GAP_W{1'b0}}, thr_q};
            SEL_STAT: rd_mux = stat_view;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_stb) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/wkstat_chk.sv
module wkstat_chk #(
    parameter int         PRIO_W    = 4,
    parameter int         NUM_FLAGS = 4,
    parameter bit         SAT_TOP   = 1'b1,
    parameter logic [7:0] WAKE_OFS  = 8'h13,
    parameter logic [7:0] STAT_OFS  = 8'h1F
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [7:0]           bus_addr,
    input logic [7:0]           bus_rdata,
    input logic [NUM_FLAGS-1:0] evt_pulse,
    input logic                 irq_req_valid,
    input logic [PRIO_W-1:0]    irq_req_prio,
    input logic                 wake_req,
    input logic                 irq_out,
    input logic [PRIO_W-1:0]    thr_q
);

    logic stat_wr;
    assign stat_wr = bus_sel && bus_wr && (bus_addr == STAT_OFS);

    AST_WAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_valid |=> !wake_req); // R5

    AST_WAKE_PRIO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_prio == '0) |=> !wake_req); // R4

    AST_THR_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        !SAT_TOP || (thr_q != '1)); // R3

    AST_EVT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> irq_out); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !stat_wr) |=> irq_out); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && (evt_pulse == '0)) |=> !irq_out); // R9

    AST_WAKE_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == WAKE_OFS)) |=> (bus_rdata[6:4] == 3'b000)); // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R11

endmodule

bind wkstat_regs wkstat_chk #(
    .PRIO_W    (PRIO_W),
    .NUM_FLAGS (NUM_FLAGS),
    .SAT_TOP   (SAT_TOP),
    .WAKE_OFS  (WAKE_OFS),
    .STAT_OFS  (STAT_OFS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .evt_pulse     (evt_pulse),
    .irq_req_valid (irq_req_valid),
    .irq_req_prio  (irq_req_prio),
    .wake_req      (wake_req),
    .irq_out       (irq_out),
    .thr_q         (thr_q)
);

// File: tb/sim_wkstat_regs.sv
module sim_wkstat_regs;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] evt_pulse = '0;
    logic       irq_req_valid = 1'b0;
    logic [3:0] irq_req_prio = '0;
    logic       wake_req;
    logic       irq_out;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wkstat_regs u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .evt_pulse     (evt_pulse),
        .irq_req_valid (irq_req_valid),
        .irq_req_prio  (irq_req_prio),
        .wake_req      (wake_req),
        .irq_out       (irq_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic wake_probe(input logic v, input logic [3:0] p, input logic exp, input string tag);
        @(negedge clk);
        irq_req_valid = v; irq_req_prio = p;
        @(negedge clk);
        check(tag, {7'd0, wake_req}, {7'd0, exp});
        irq_req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 wake_req", {7'd0, wake_req}, 8'h00);
        check("R1 irq_out", {7'd0, irq_out}, 8'h00);
        bus_read(8'h13, d); check("R1 wake reg", d, 8'h00);
        bus_read(8'h1F, d); check("R1 status reg", d, 8'h00);
    endtask

    task automatic t_wake_reg();
        logic [7:0] d;
        bus_write(8'h13, 8'h85); bus_read(8'h13, d); check("R2 readback", d, 8'h85);
        bus_write(8'h13, 8'hFF); bus_read(8'h13, d); check("R3 saturate, R2 gap", d, 8'h8E);
        bus_write(8'h13, 8'h0D); bus_read(8'h13, d); check("R3 no saturate", d, 8'h0D);
        repeat (3) @(negedge clk);
        check("R11 hold", bus_rdata, 8'h0D);
    endtask

    task automatic t_wake_cmp();
        bus_write(8'h13, 8'h85);
        wake_probe(1'b1, 4'd6, 1'b1, "R4 above threshold");
        wake_probe(1'b1, 4'd5, 1'b0, "R4 equal threshold");
        wake_probe(1'b0, 4'd9, 1'b0, "R5 masked");
        bus_write(8'h13, 8'h05);
        wake_probe(1'b1, 4'd9, 1'b0, "R5 disabled");
    endtask

    task automatic t_status();
        logic [7:0] d;
        pulse(4'b0001);
        check("R9 irq set", {7'd0, irq_out}, 8'h01);
        bus_read(8'h1F, d); check("R6 flag0 at bit7", d, 8'h80);
        pulse(4'b1010);
        bus_read(8'h1F, d); check("R6 flags 1,3", d, 8'hD0);
        bus_write(8'h1F, 8'h40); bus_read(8'h1F, d); check("R7 w1c", d, 8'h90);
        bus_write(8'h1F, 8'h00); bus_read(8'h1F, d); check("R7 w0 no effect", d, 8'h90);
        bus_write(8'h1F, 8'h0F); bus_read(8'h1F, d); check("R6 low bits no flags", d, 8'h90);
        @(negedge clk);
        evt_pulse = 4'b0100;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1F; bus_wdata = 8'hA0;
        @(negedge clk);
        evt_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(8'h1F, d); check("R8 set wins", d, 8'h30);
        check("R9 irq held", {7'd0, irq_out}, 8'h01);
        bus_write(8'h1F, 8'hFF);
        check("R9 irq clear", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        bus_write(8'h13, 8'h83);
        pulse(4'b0001);
        bus_write(8'h14, 8'hFF);
        bus_write(8'h1E, 8'hFF);
        bus_read(8'h13, d); check("R10 wake untouched", d, 8'h83);
        bus_read(8'h1F, d); check("R10 status untouched", d, 8'h80);
        bus_read(8'h14, d); check("R10 read zero", d, 8'h00);
        bus_write(8'h1F, 8'h80);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wake_reg();
        t_wake_cmp();
        t_status();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule